// File: doc/BRIEF.md
# I2C Register-Driven Byte Master

This block is an I2C bus master with a small register file on a CPU register bus. Bus activity comes from side effects of register accesses. Setting the master-select bit claims the bus with a START condition, and clearing it ends the transaction with a STOP. A restart bit issues a repeated START while the bus is still held.

In transmit mode, each write to the data register shifts that byte onto SDA. In receive mode, each read of the data register starts reception of the next byte. The first read after switching to receive only primes the transfer and returns whatever the data register last held. Each later read returns the byte that was just received and starts the next one.

Software supplies the 7-bit slave address and the R/W bit as the first data byte after START. The SCL rate is set by a fixed divider parameter. Slaves that stretch the clock, multi-master arbitration and slave operation are not handled.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, the data register (address 2) reads 0x00, the control (address 0) and status (address 1) registers read 0x00, and `scl_o` and `sda_o` are both 1 (released).
- R2: A control write that changes master-select (bit 0) from 0 to 1 produces a START, meaning SDA falls while SCL is high. Status bit 1 (bus busy) then reads 1.
- R3: With master-select = 1 and transmit mode (control bit 1) = 1, a data-register write sends that byte MSB first in eight SCL clocks. Bit 0 is sent unchanged, so the R/W bit is exactly what software wrote.
- R4: Status bit 0 (byte done) sets only after the ninth (acknowledge) SCL clock of a byte, and any access to the data register clears it. A data-register read in transmit mode returns the register and starts no transfer.
- R5: During transmit, the level of SDA sampled on the ninth clock is latched into status bit 2 (0 = acknowledged, 1 = not acknowledged).
- R6: A control write with master-select = 1 and restart (bit 2) = 1, made while master-select is already 1, produces a repeated START with no STOP in between, and bus busy stays 1. The restart bit always reads back as 0.
- R7: A control write that changes master-select from 1 to 0 produces a STOP, meaning SDA rises while SCL is high. Bus busy then clears and both lines are released once status bit 3 (activity pending) reads 0.
- R8: With master-select = 1 and transmit mode = 0, a data-register read returns the register's current content and starts reception of one byte. The first such read returns stale data, and each later read returns the byte received by the previous one.
- R9: After each received byte, the master drives SDA low (ACK) on the ninth clock if control bit 3 was 1 when the read was started, and leaves it high (NACK) otherwise.
- R10: A data-register write made while master-select is 0 updates the register but causes no SCL activity and does not set byte done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data is valid on `reg_rdata` one cycle later |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_o | output | 1 | SCL drive; 0 pulls the line low, 1 releases it |
| sda_o | output | 1 | SDA drive; 0 pulls the line low, 1 releases it |

## Verification
The block runs against a behavioural slave on an open-drain bus model. A table of transmit transactions checks several patterns against what the slave captured:
- 0xA5 shows whether the bit order is reversed.
- 0x01 and 0x80 each isolate one end bit of the byte.
- A wrong address byte separates a NACK from an ACK in the latched status.

A receive sequence fetches three distinct slave bytes. It shows the stale dummy-read value, the one-read lag between a read and its data, and an ACK/NACK choice that changes from byte to byte. A restart sequence tells a repeated START apart from a STOP followed by a START by counting both conditions on the wire. A data write with master-select clear checks that the register changes while the bus stays quiet.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  typedef enum logic [2:0] {
    OP_START,
    OP_RESTART,
    OP_WRITE,
    OP_READ,
    OP_STOP
  } i2cb_op_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_RESTART,
    ST_STOP,
    ST_BITS
  } i2cb_state_t;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_DATA = 2'd2;

  localparam int CB_MSEL    = 0;
  localparam int CB_TX      = 1;
  localparam int CB_RESTART = 2;
  localparam int CB_ACKEN   = 3;
endpackage

// File: rtl/i2cb_tick.sv
module i2cb_tick #(
  parameter int DIV = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/i2cb_busmon.sv
module i2cb_busmon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic bus_busy
);
  logic [SYNC-1:0] scl_s, sda_s;
  logic scl_p, sda_p;
  logic scl_n, sda_n;

  assign scl_n = scl_s[SYNC-1];
  assign sda_n = sda_s[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_s    <= '1;
      sda_s    <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
      bus_busy <= 1'b0;
    end else begin
      scl_s <= {scl_s[SYNC-2:0], scl_i};
      sda_s <= {sda_s[SYNC-2:0], sda_i};
      scl_p <= scl_n;
      sda_p <= sda_n;
      if (scl_n && scl_p && sda_p && !sda_n) bus_busy <= 1'b1;
      else if (scl_n && scl_p && !sda_p && sda_n) bus_busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
  import i2cb_pkg::*;
#(
  parameter int DIV = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  i2cb_op_t   op,
  input  logic [7:0] wbyte,
  input  logic       ack_en,
  input  logic       sda_i,
  output logic       scl_o,
  output logic       sda_o,
  output logic       busy,
  output logic       held,
  output logic       done,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       rx_nack
);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  i2cb_state_t state;
  logic [1:0]  ph;
  logic [3:0]  bitn;
  logic [7:0]  sh;
  logic        smp, rd_q, ack_q, tick;
  logic        scl_d, sda_d;

  assign busy = (state != ST_IDLE);

  i2cb_tick #(.DIV(DIV)) i_tick (
    .clk (clk),
    .rst (rst),
    .run (busy),
    .tick(tick)
  );

  always_comb begin
    scl_d = 1'b1;
    sda_d = 1'b1;
    case (state)
      ST_IDLE:    begin scl_d = !held;              sda_d = !held;       end
      ST_START:   begin scl_d = (ph != 2'd3);       sda_d = (ph == 2'd0); end
      ST_RESTART: begin scl_d = (ph == 2'd1) || (ph == 2'd2); sda_d = (ph <= 2'd1); end
      ST_STOP:    begin scl_d = (ph != 2'd0);       sda_d = (ph >= 2'd2); end
      ST_BITS: begin
        scl_d = (ph == 2'd1) || (ph == 2'd2);
        if (bitn == ACK_SLOT) sda_d = rd_q ? !ack_q : 1'b1;
        else                  sda_d = rd_q ? 1'b1 : sh[7];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ph       <= '0;
      bitn     <= '0;
      sh       <= '0;
      smp      <= 1'b1;
      rd_q     <= 1'b0;
      ack_q    <= 1'b0;
      held     <= 1'b0;
      done     <= 1'b0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
      rx_nack  <= 1'b0;
      scl_o    <= 1'b1;
      sda_o    <= 1'b1;
    end else begin
      done     <= 1'b0;
      rx_valid <= 1'b0;
      scl_o    <= scl_d;
      sda_o    <= sda_d;
      if (state == ST_IDLE) begin
        ph   <= '0;
        bitn <= '0;
        if (go) begin
          case (op)
            OP_START:   state <= ST_START;
            OP_RESTART: state <= ST_RESTART;
            OP_STOP:    state <= ST_STOP;
            OP_WRITE: begin state <= ST_BITS; sh <= wbyte; rd_q <= 1'b0; end
            OP_READ:  begin state <= ST_BITS; sh <= 8'hFF; rd_q <= 1'b1; ack_q <= ack_en; end
            default: ;
          endcase
        end
      end else if (tick) begin
        if (ph == 2'd2 && state == ST_BITS) begin
          smp <= sda_i;
          if (bitn == ACK_SLOT && !rd_q) rx_nack <= sda_i;
        end
        if (ph != 2'd3) begin
          ph <= ph + 1'b1;
        end else if (state == ST_BITS && bitn != ACK_SLOT) begin
          sh   <= {sh[6:0], smp};
          bitn <= bitn + 1'b1;
          ph   <= '0;
        end else begin
          state <= ST_IDLE;
          held  <= (state != ST_STOP);
          if (state == ST_BITS) begin
            done     <= 1'b1;
            rx_valid <= rd_q;
            if (rd_q) rx_byte <= sh;
          end
        end
      end
    end
  end

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BITS && scl_o && $past(scl_o)) |-> $stable(sda_o)); // R3

  AST_LINES_FREE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && !held) |-> (scl_o && sda_o)); // R7
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cb_pkg::*;
#(
  parameter int DIV = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_o,
  output logic       sda_o
);
  logic msel_q, tx_q, acken_q, byte_done_q;
  logic [7:0] data_q;
  logic pend_start, pend_restart, pend_wr, pend_rd, pend_stop;
  logic go;
  i2cb_op_t go_op;
  logic eng_busy, eng_held, eng_done, eng_rx_valid, eng_rx_nack, bus_busy;
  logic [7:0] eng_rx_byte;
  logic data_acc, active;

  assign data_acc = (reg_wr || reg_rd) && (reg_addr == RA_DATA);
  assign active   = eng_busy || pend_start || pend_restart || pend_wr || pend_rd || pend_stop;

  always_comb begin
    go    = !eng_busy;
    go_op = OP_START;
    if (pend_start)        go_op = OP_START;
    else if (pend_restart) go_op = OP_RESTART;
    else if (pend_wr)      go_op = OP_WRITE;
    else if (pend_rd)      go_op = OP_READ;
    else if (pend_stop)    go_op = OP_STOP;
    else                   go    = 1'b0;
  end

  i2cb_engine #(.DIV(DIV)) i_engine (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .op      (go_op),
    .wbyte   (data_q),
    .ack_en  (acken_q),
    .sda_i   (sda_i),
    .scl_o   (scl_o),
    .sda_o   (sda_o),
    .busy    (eng_busy),
    .held    (eng_held),
    .done    (eng_done),
    .rx_valid(eng_rx_valid),
    .rx_byte (eng_rx_byte),
    .rx_nack (eng_rx_nack)
  );

  i2cb_busmon #(.SYNC(2)) i_busmon (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .bus_busy(bus_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      msel_q       <= 1'b0;
      tx_q         <= 1'b0;
      acken_q      <= 1'b0;
      byte_done_q  <= 1'b0;
      data_q       <= '0;
      pend_start   <= 1'b0;
      pend_restart <= 1'b0;
      pend_wr      <= 1'b0;
      pend_rd      <= 1'b0;
      pend_stop    <= 1'b0;
      reg_rdata    <= '0;
    end else begin
      if (go) begin
        case (go_op)
          OP_START:   pend_start   <= 1'b0;
          OP_RESTART: pend_restart <= 1'b0;
          OP_WRITE:   pend_wr      <= 1'b0;
          OP_READ:    pend_rd      <= 1'b0;
          default:    pend_stop    <= 1'b0;
        endcase
      end
      if (eng_done)      byte_done_q <= 1'b1;
      else if (data_acc) byte_done_q <= 1'b0;
      if (eng_rx_valid) data_q <= eng_rx_byte;
      if (reg_wr) begin
        case (reg_addr)
          RA_CTRL: begin
            msel_q  <= reg_wdata[CB_MSEL];
            tx_q    <= reg_wdata[CB_TX];
            acken_q <= reg_wdata[CB_ACKEN];
            if (reg_wdata[CB_MSEL] && !msel_q) pend_start <= 1'b1;
            if (!reg_wdata[CB_MSEL] && msel_q) pend_stop  <= 1'b1;
            if (reg_wdata[CB_MSEL] && msel_q && reg_wdata[CB_RESTART]) pend_restart <= 1'b1;
          end
          RA_DATA: begin
            data_q <= reg_wdata;
            if (msel_q && tx_q) pend_wr <= 1'b1;
          end
          default: ;
        endcase
      end
      if (reg_rd) begin
        case (reg_addr)
          RA_CTRL: reg_rdata <= {4'b0, acken_q, 1'b0, tx_q, msel_q};
          RA_STAT: reg_rdata <= {4'b0, active, eng_rx_nack, bus_busy, byte_done_q};
          RA_DATA: reg_rdata <= data_q;
          default: reg_rdata <= '0;
        endcase
        if (reg_addr == RA_DATA && msel_q && !tx_q) pend_rd <= 1'b1;
      end
    end
  end

  AST_DONE_AFTER_ENGINE: assert property (@(posedge clk) disable iff (rst)
    $rose(byte_done_q) |-> $past(eng_done)); // R4

  AST_BUSY_RISES_IN_XFER: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_busy) |-> eng_busy); // R2

  AST_RESTART_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (go && go_op == OP_RESTART) |-> bus_busy); // R6
endmodule

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
  localparam int DIV = 4;
  localparam logic [6:0] SL_ADDR = 7'h2A;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;
  // {expected nack, address byte, data byte}
  localparam logic [16:0] VEC [0:3] = '{
    {1'b0, 8'h54, 8'hA5},
    {1'b0, 8'h54, 8'h01},
    {1'b0, 8'h54, 8'h80},
    {1'b1, 8'h22, 8'h3C}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic scl_o, sda_o, sl_sda, scl_line, sda_line;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign scl_line = scl_o;
  assign sda_line = sda_o & sl_sda;

  i2c_byte_master #(.DIV(DIV)) i_i2c_byte_master (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_line), .sda_i(sda_line),
    .scl_o(scl_o), .sda_o(sda_o)
  );

  // behavioural slave
  logic p_scl = 1'b1, p_sda = 1'b1;
  int bitn = 8, starts = 0, stops = 0, wr_n = 0, mack_n = 0, tx_k = 0;
  int scl_rises = 0, scl_low = 0;
  bit fresh = 1, addr_ph = 0, sending = 0, matched = 0;
  logic [7:0] rx_sh = '0, tx_sh = '0, rw_log = '0;
  logic [7:0] wr_log [0:31];
  logic mack_log [0:31];

  always @(negedge clk) begin
    if (rst) begin
      sl_sda = 1'b1; bitn = 8; fresh = 1; addr_ph = 0; sending = 0; matched = 0;
    end else begin
      if (!scl_line) scl_low++;
      if (scl_line && !p_scl) scl_rises++;
      if (scl_line && p_scl && p_sda && !sda_line) begin
        starts++; bitn = 8; fresh = 1; addr_ph = 1; sending = 0; sl_sda = 1'b1;
      end else if (scl_line && p_scl && !p_sda && sda_line) begin
        stops++; bitn = 8; fresh = 1; addr_ph = 0; sending = 0; matched = 0; sl_sda = 1'b1;
      end else if (scl_line && !p_scl) begin
        if (bitn < 8 && !sending) rx_sh = {rx_sh[6:0], sda_line};
        if (bitn == 8 && sending) begin
          mack_log[mack_n] = sda_line; mack_n++;
          if (sda_line) begin sending = 0; matched = 0; end
        end
      end else if (!scl_line && p_scl) begin
        bitn = (bitn == 8) ? 0 : bitn + 1;
        sl_sda = 1'b1;
        if (bitn == 0) begin
          if (!fresh) begin
            if (addr_ph) begin
              addr_ph = 0; rw_log = rx_sh;
              matched = (rx_sh[7:1] == SL_ADDR); sending = matched && rx_sh[0];
            end else if (matched && !sending) begin
              wr_log[wr_n] = rx_sh; wr_n++;
            end
          end
          fresh = 0;
          if (sending) begin tx_sh = 8'h5A + 8'h13 * tx_k[7:0]; tx_k++; sl_sda = tx_sh[7]; end
        end else if (bitn < 8) begin
          if (sending) sl_sda = tx_sh[7 - bitn];
        end else if (!sending && (addr_ph ? (rx_sh[7:1] == SL_ADDR) : matched)) begin
          sl_sda = 1'b0;
        end
      end
      p_scl = scl_line; p_sda = sda_line;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_stat(input int bitpos, input logic val, input string req);
    logic [7:0] s;
    int n = 0;
    rd(A_STAT, s);
    while (s[bitpos] !== val && n < 5000) begin rd(A_STAT, s); n++; end
    check(s[bitpos] === val, req, s[bitpos], val);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int s0, p0, m0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(A_DATA, v); check(v == 8'h00, "R1 data", v, 0);
    rd(A_CTRL, v); check(v == 8'h00, "R1 ctrl", v, 0);
    rd(A_STAT, v); check(v == 8'h00, "R1 stat", v, 0);
    check(scl_o && sda_o, "R1 lines", {scl_o, sda_o}, 3);

    // R10 data write with master-select clear
    scl_low = 0;
    wr(A_DATA, 8'h99);
    repeat (200) @(negedge clk);
    check(scl_low == 0, "R10 scl quiet", scl_low, 0);
    rd(A_STAT, v); check(v[0] == 1'b0, "R10 no done", v[0], 0);
    rd(A_DATA, v); check(v == 8'h99, "R10 data kept", v, 8'h99);

    // transmit vector table: R2 R3 R4 R5 R7
    for (int i = 0; i < 4; i++) begin
      s0 = starts; p0 = stops;
      wr(A_CTRL, 8'h03);
      wait_stat(3, 1'b0, "R2 start finish");
      rd(A_STAT, v); check(v[1] == 1'b1, "R2 bus busy", v[1], 1);
      check(starts == s0 + 1, "R2 start seen", starts, s0 + 1);
      scl_rises = 0;
      wr(A_DATA, VEC[i][15:8]);
      wait_stat(0, 1'b1, "R4 addr done");
      check(scl_rises == 9, "R4 nine clocks", scl_rises, 9);
      rd(A_STAT, v); check(v[2] == VEC[i][16], "R5 ack status", v[2], VEC[i][16]);
      check(rw_log == VEC[i][15:8], "R3 address byte", rw_log, VEC[i][15:8]);
      if (!VEC[i][16]) begin
        wr(A_DATA, VEC[i][7:0]);
        wait_stat(0, 1'b1, "R4 data done");
        check(wr_n > 0 && wr_log[wr_n-1] == VEC[i][7:0], "R3 msb first", wr_log[wr_n-1], VEC[i][7:0]);
        rd(A_DATA, v); check(v == VEC[i][7:0], "R4 tx read", v, VEC[i][7:0]);
        rd(A_STAT, v); check(v[0] == 1'b0, "R4 done cleared", v[0], 0);
      end
      wr(A_CTRL, 8'h00);
      wait_stat(3, 1'b0, "R7 stop finish");
      rd(A_STAT, v); check(v[1] == 1'b0, "R7 bus free", v[1], 0);
      check(stops == p0 + 1, "R7 stop seen", stops, p0 + 1);
      check(scl_o && sda_o, "R7 released", {scl_o, sda_o}, 3);
    end

    // R6 repeated start
    s0 = starts; p0 = stops;
    wr(A_CTRL, 8'h03);
    wr(A_DATA, 8'h54); wait_stat(0, 1'b1, "R6 addr");
    wr(A_DATA, 8'h11); wait_stat(0, 1'b1, "R6 byte");
    wr(A_CTRL, 8'h07);
    wait_stat(3, 1'b0, "R6 restart finish");
    rd(A_STAT, v); check(v[1] == 1'b1, "R6 still busy", v[1], 1);
    check(starts == s0 + 2, "R6 second start", starts, s0 + 2);
    check(stops == p0, "R6 no stop", stops, p0);
    rd(A_CTRL, v); check(v == 8'h03, "R6 restart reads 0", v, 8'h03);
    wr(A_DATA, 8'h54); wait_stat(0, 1'b1, "R6 readdr");
    rd(A_STAT, v); check(v[2] == 1'b0, "R6 readdr ack", v[2], 0);
    wr(A_DATA, 8'h22); wait_stat(0, 1'b1, "R6 byte2");
    check(wr_log[wr_n-1] == 8'h22, "R6 byte after restart", wr_log[wr_n-1], 8'h22);
    wr(A_CTRL, 8'h00); wait_stat(3, 1'b0, "R6 stop");
    check(stops == p0 + 1, "R6 final stop", stops, p0 + 1);

    // R8 R9 receive with dummy read
    m0 = mack_n; tx_k = 0;
    wr(A_CTRL, 8'h0B);
    wr(A_DATA, 8'h55); wait_stat(0, 1'b1, "R8 addr");
    wr(A_CTRL, 8'h09);
    rd(A_DATA, v); check(v == 8'h55, "R8 dummy read stale", v, 8'h55);
    wait_stat(0, 1'b1, "R8 byte0");
    rd(A_DATA, v); check(v == 8'h5A, "R8 byte0", v, 8'h5A);
    wait_stat(0, 1'b1, "R8 byte1");
    wr(A_CTRL, 8'h01);
    rd(A_DATA, v); check(v == 8'h6D, "R8 byte1", v, 8'h6D);
    wait_stat(0, 1'b1, "R8 byte2");
    wr(A_CTRL, 8'h00); wait_stat(3, 1'b0, "R8 stop");
    rd(A_DATA, v); check(v == 8'h80, "R8 byte2", v, 8'h80);
    check(mack_n == m0 + 3, "R9 ack slots", mack_n, m0 + 3);
    check(mack_log[m0] == 1'b0, "R9 ack0", mack_log[m0], 0);
    check(mack_log[m0+1] == 1'b0, "R9 ack1", mack_log[m0+1], 0);
    check(mack_log[m0+2] == 1'b1, "R9 nack", mack_log[m0+2], 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule